// File: doc/BRIEF.md
# Video Processor CPU Register Bank

This block is the processor-side register file of a tile-based video engine. A host issues single-cycle accesses through a strobe, a write-enable and a 3-bit port index. Two ports hold plain configuration bytes: a control byte and a 6-bit mask. The status port reports three flags that the rendering logic raises, and reading it clears some of that state. One pair of ports addresses and moves bytes in a 256-byte sprite attribute memory. Two ports share one first/second-write toggle. One of them loads horizontal then vertical scroll. The other assembles a 14-bit video memory address from a high byte and then a low byte.

The data port moves bytes at the current video address and then steps that address by 1 or 32. Reads through this port come back one access late through a buffer. Addresses with bit 13 set go to a 2 KiB internal nametable RAM. An input from the cartridge chooses how that RAM is mirrored. Lower addresses read an external pattern memory through an address output and a data input. A free-running dot and scanline counter keeps the sprite address at zero during the sprite fetch part of each line.

Top module: `vid_regbank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) zeroes the control, mask, scroll, video address, read buffer, read data, toggle, sprite address and flags, and sets the dot and scanline counters to 0.
- R2: A write to port 0 stores the whole byte on `ctrl_o`. A write to port 1 stores bits 5..0 on `mask_o`. Control bit 2 picks the data-port step: 32 when set, 1 when clear.
- R3: A read of port 2 returns {vblank, sprite-zero hit, overflow, 5'b0} in bits 7..0. It then clears vblank and the shared toggle, and leaves the other two flags alone. The set pulses raise flags and `flags_clr` clears all three.
- R4: Port 6 writes use the toggle. With toggle 0 the address becomes {byte[5:0], 8'h00}. With toggle 1 the byte is ORed into bits 7..0 and the result is held to 14 bits. Every write inverts the toggle.
- R5: Port 5 writes use the same toggle. With toggle 0 they load `scroll_x_o`, with toggle 1 they load `scroll_y_o`, and every write inverts the toggle.
- R6: A port 7 read returns the buffer contents. The buffer is then reloaded from the current address, and the address advances by the step modulo 2^14.
- R7: A port 7 write stores the byte into the nametable RAM when address bit 13 is set, and otherwise drops it. Either way the address advances by the step.
- R8: Nametable addresses drop bit 12, so 0x3000..0x3FFF alias 0x2000..0x2FFF. The 1 KiB table number t is taken from bits 11..10. With `mirror_vert`=0, tables 1 and 2 move down 0x400 and table 3 moves down 0x800. With `mirror_vert`=1, tables 2 and 3 move down 0x800.
- R9: A port 3 write sets the sprite address. A port 4 write stores at that address and then increments it modulo 256. A port 4 read returns the stored byte and does not increment.
- R10: The dot counter counts 0..340 and wraps. Each wrap advances the scanline counter, which counts 0..261 and wraps.
- R11: Whenever the dot count is between 257 and 320 inclusive, the next sprite address is 0. This overrides any port 3 or port 4 update.
- R12: Reads of ports 0, 1, 3, 5 and 6 return 0. A write to port 2 changes nothing.
- R13: Reads below 0x2000 reload the buffer from `pat_rdata` while `pat_addr` shows address bits 12..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_stb | input | 1 | Single-cycle access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_port | input | 3 | Port index |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid from the cycle after a read strobe, held until the next read |
| mirror_vert | input | 1 | Nametable mirroring select from the cartridge |
| vblank_set | input | 1 | Raises the vblank flag |
| sprite0_set | input | 1 | Raises the sprite-zero hit flag |
| overflow_set | input | 1 | Raises the sprite overflow flag |
| flags_clr | input | 1 | Clears all three flags (a set pulse in the same cycle wins) |
| pat_addr | output | 13 | Pattern memory read address |
| pat_rdata | input | 8 | Pattern memory read data, combinational |
| ctrl_o | output | 8 | Control byte |
| mask_o | output | 6 | Mask bits |
| scroll_x_o | output | 8 | Horizontal scroll |
| scroll_y_o | output | 8 | Vertical scroll |
| vram_addr_o | output | 14 | Current video memory address |
| dot_o | output | 9 | Dot counter |
| line_o | output | 9 | Scanline counter |

## Verification
The sprite-address override is the hardest case to reach, because it depends on where the free-running dot counter happens to be. The bench waits for `dot_o` to reach a chosen value before each sprite-memory phase. It then either fits a whole phase before dot 257 or deliberately accesses the memory inside the 257..320 window. A second hard case is a buffered read that crosses from pattern space into nametable space. Every data-port read returns the byte fetched on the previous read. The bench therefore steps the address across 0x1FFF and expects the first nametable byte one read after the address crosses. Mirroring is swept over all four tables in both modes, through both the 0x2000 and 0x3000 windows. Expected contents come from a model that applies the table offsets by subtraction.

// File: rtl/vr_pkg.sv
package vr_pkg;

    localparam int DW   = 8;
    localparam int VA_W = 14;
    localparam int OA_W = 8;
    localparam int MK_W = 6;
    localparam int STEP_BIT = 2;

    typedef enum logic [2:0] {
        P_CTRL   = 3'd0,
        P_MASK   = 3'd1,
        P_STAT   = 3'd2,
        P_OADDR  = 3'd3,
        P_ODATA  = 3'd4,
        P_SCROLL = 3'd5,
        P_VADDR  = 3'd6,
        P_DATA   = 3'd7
    } port_e;

    typedef struct packed {
        logic [DW-1:0]   ctrl;
        logic [MK_W-1:0] mask;
        logic [DW-1:0]   scroll_x;
        logic [DW-1:0]   scroll_y;
        logic [VA_W-1:0] vaddr;
        logic            toggle;
        logic [DW-1:0]   rbuf;
        logic [OA_W-1:0] oam_addr;
        logic            vblank;
        logic            hit0;
        logic            ovf;
        logic [DW-1:0]   rdata;
    } regs_t;

endpackage

// File: rtl/vr_ram.sv
module vr_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/vr_ntmap.sv
module vr_ntmap #(
    parameter int TBL_AW = 10
) (
    input  logic [TBL_AW+1:0] win_off,
    input  logic              mirror_vert,
    output logic [TBL_AW:0]   phys
);
    logic [1:0] tbl;
    logic       bank;

    always_comb begin
        tbl  = win_off[TBL_AW+1:TBL_AW];
        bank = mirror_vert ? tbl[0] : tbl[1];
        phys = {bank, win_off[TBL_AW-1:0]};
    end

endmodule

// File: rtl/vr_beam.sv
module vr_beam #(
    parameter int DOTS  = 341,
    parameter int LINES = 262,
    localparam int DOT_W  = $clog2(DOTS),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line
);
    localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

    logic [DOT_W-1:0]  dot_d, dot_q;
    logic [LINE_W-1:0] line_d, line_q;

    always_comb begin
        dot_d  = dot_q + 1'b1;
        line_d = line_q;
        if (dot_q == DOT_LAST) begin
            dot_d  = '0;
            line_d = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dot_q  <= '0;
            line_q <= '0;
        end else begin
            dot_q  <= dot_d;
            line_q <= line_d;
        end
    end

    assign dot  = dot_q;
    assign line = line_q;

    AST_DOT_BOUND: assert property (@(posedge clk) disable iff (rst)
        dot_q <= DOT_LAST); // R10
    AST_LINE_BOUND: assert property (@(posedge clk) disable iff (rst)
        line_q <= LINE_LAST); // R10
    AST_DOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (dot_q == DOT_LAST) |=> (dot_q == '0)); // R10
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (dot_q == DOT_LAST && line_q != LINE_LAST) |=> (line_q == $past(line_q) + 1'b1)); // R10
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dot_q != DOT_LAST) |=> $stable(line_q)); // R10

endmodule

// File: rtl/vid_regbank.sv
module vid_regbank
    import vr_pkg::*;
#(
    parameter int DOTS       = 341,
    parameter int LINES      = 262,
    parameter int OAM_WIN_LO = 257,
    parameter int OAM_WIN_HI = 320,
    parameter int NT_TBL_AW  = 10,
    localparam int DOT_W  = $clog2(DOTS),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_stb,
    input  logic              acc_we,
    input  logic [2:0]        acc_port,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    input  logic              mirror_vert,
    input  logic              vblank_set,
    input  logic              sprite0_set,
    input  logic              overflow_set,
    input  logic              flags_clr,
    output logic [12:0]       pat_addr,
    input  logic [7:0]        pat_rdata,
    output logic [7:0]        ctrl_o,
    output logic [5:0]        mask_o,
    output logic [7:0]        scroll_x_o,
    output logic [7:0]        scroll_y_o,
    output logic [13:0]       vram_addr_o,
    output logic [DOT_W-1:0]  dot_o,
    output logic [LINE_W-1:0] line_o
);
    localparam int NT_AW = NT_TBL_AW + 1;
    localparam logic [DOT_W-1:0] WIN_LO = DOT_W'(OAM_WIN_LO);
    localparam logic [DOT_W-1:0] WIN_HI = DOT_W'(OAM_WIN_HI);
    localparam logic [VA_W-1:0]  STEP_WIDE = VA_W'(32);
    localparam logic [VA_W-1:0]  STEP_ONE  = VA_W'(1);

    regs_t r_d, r_q;

    port_e               port_w;
    logic [DOT_W-1:0]    dot_w;
    logic [LINE_W-1:0]   line_w;
    logic                in_win;
    logic [VA_W-1:0]     step_w;
    logic                is_nt;
    logic [NT_AW-1:0]    nt_idx;
    logic [DW-1:0]       nt_rd;
    logic [DW-1:0]       oam_rd;
    logic                nt_we;
    logic                oam_we;

    assign port_w = port_e'(acc_port);

    vr_beam #(.DOTS(DOTS), .LINES(LINES)) u_beam (
        .clk  (clk),
        .rst  (rst),
        .dot  (dot_w),
        .line (line_w)
    );

    vr_ntmap #(.TBL_AW(NT_TBL_AW)) u_ntmap (
        .win_off     (r_q.vaddr[NT_TBL_AW+1:0]),
        .mirror_vert (mirror_vert),
        .phys        (nt_idx)
    );

    vr_ram #(.AW(NT_AW), .DW(DW)) u_nt_ram (
        .clk   (clk),
        .we    (nt_we),
        .addr  (nt_idx),
        .wdata (acc_wdata),
        .rdata (nt_rd)
    );

    vr_ram #(.AW(OA_W), .DW(DW)) u_oam_ram (
        .clk   (clk),
        .we    (oam_we),
        .addr  (r_q.oam_addr),
        .wdata (acc_wdata),
        .rdata (oam_rd)
    );

    always_comb begin
        in_win = (dot_w >= WIN_LO) && (dot_w <= WIN_HI);
        step_w = r_q.ctrl[STEP_BIT] ? STEP_WIDE : STEP_ONE;
        is_nt  = r_q.vaddr[VA_W-1];
    end

    always_comb begin
        r_d    = r_q;
        nt_we  = 1'b0;
        oam_we = 1'b0;

        if (acc_stb && acc_we) begin
            case (port_w)
                P_CTRL:  r_d.ctrl = acc_wdata;
                P_MASK:  r_d.mask = acc_wdata[MK_W-1:0];
                P_OADDR: r_d.oam_addr = acc_wdata;
                P_ODATA: begin
                    oam_we     = 1'b1;
                    r_d.oam_addr = r_q.oam_addr + 1'b1;
                end
                P_SCROLL: begin
                    if (r_q.toggle) r_d.scroll_y = acc_wdata;
                    else            r_d.scroll_x = acc_wdata;
                    r_d.toggle = ~r_q.toggle;
                end
                P_VADDR: begin
                    if (r_q.toggle) r_d.vaddr = r_q.vaddr | {6'b0, acc_wdata};
                    else            r_d.vaddr = {acc_wdata[5:0], 8'h00};
                    r_d.toggle = ~r_q.toggle;
                end
                P_DATA: begin
                    nt_we     = is_nt;
                    r_d.vaddr = r_q.vaddr + step_w;
                end
                default: ;
            endcase
        end else if (acc_stb) begin
            r_d.rdata = '0;
            case (port_w)
                P_STAT: begin
                    r_d.rdata  = {r_q.vblank, r_q.hit0, r_q.ovf, 5'b0};
                    r_d.vblank = 1'b0;
                    r_d.toggle = 1'b0;
                end
                P_ODATA: r_d.rdata = oam_rd;
                P_DATA: begin
                    r_d.rdata = r_q.rbuf;
                    r_d.rbuf  = is_nt ? nt_rd : pat_rdata;
                    r_d.vaddr = r_q.vaddr + step_w;
                end
                default: ;
            endcase
        end

        if (flags_clr) begin
            r_d.vblank = 1'b0;
            r_d.hit0   = 1'b0;
            r_d.ovf    = 1'b0;
        end
        if (vblank_set)   r_d.vblank = 1'b1;
        if (sprite0_set)  r_d.hit0   = 1'b1;
        if (overflow_set) r_d.ovf    = 1'b1;

        if (in_win) r_d.oam_addr = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign acc_rdata   = r_q.rdata;
    assign pat_addr    = r_q.vaddr[VA_W-2:0];
    assign ctrl_o      = r_q.ctrl;
    assign mask_o      = r_q.mask;
    assign scroll_x_o  = r_q.scroll_x;
    assign scroll_y_o  = r_q.scroll_y;
    assign vram_addr_o = r_q.vaddr;
    assign dot_o       = dot_w;
    assign line_o      = line_w;

    AST_STAT_VBL_CLR: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && !acc_we && acc_port == 3'd2 && !vblank_set) |=> !r_q.vblank); // R3
    AST_STAT_TGL_CLR: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && !acc_we && acc_port == 3'd2) |=> !r_q.toggle); // R3
    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && acc_we && (acc_port == 3'd5 || acc_port == 3'd6))
        |=> (r_q.toggle != $past(r_q.toggle))); // R4
    AST_ADDR_14B: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && acc_we && acc_port == 3'd6 && !r_q.toggle)
        |=> (vram_addr_o[7:0] == 8'h00)); // R4
    AST_DATA_STEP: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && acc_port == 3'd7) |=> (vram_addr_o == $past(vram_addr_o + step_w))); // R6
    AST_OAM_WIN: assert property (@(posedge clk) disable iff (rst)
        in_win |=> (r_q.oam_addr == '0)); // R11
    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && !acc_we && acc_port != 3'd2 && acc_port != 3'd4 && acc_port != 3'd7)
        |=> (acc_rdata == 8'h00)); // R12
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(acc_stb && !acc_we) |=> $stable(acc_rdata)); // R6

endmodule

// File: tb/vid_regbank_tb.sv
module vid_regbank_tb;
    localparam int CLK_P = 10;
    localparam int DOTS  = 341;
    localparam int LINES = 262;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_stb = 1'b0, acc_we = 1'b0;
    logic [2:0]  acc_port = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic        mirror_vert = 1'b0;
    logic        vblank_set = 1'b0, sprite0_set = 1'b0, overflow_set = 1'b0, flags_clr = 1'b0;
    logic [12:0] pat_addr;
    logic [7:0]  pat_rdata;
    logic [7:0]  ctrl_o, scroll_x_o, scroll_y_o;
    logic [5:0]  mask_o;
    logic [13:0] vram_addr_o;
    logic [8:0]  dot_o, line_o;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    logic [7:0] ntm [0:2047];

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    assign pat_rdata = pat(pat_addr);

    vid_regbank u_dut (
        .clk(clk), .rst(rst), .acc_stb(acc_stb), .acc_we(acc_we), .acc_port(acc_port),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .mirror_vert(mirror_vert),
        .vblank_set(vblank_set), .sprite0_set(sprite0_set), .overflow_set(overflow_set),
        .flags_clr(flags_clr), .pat_addr(pat_addr), .pat_rdata(pat_rdata),
        .ctrl_o(ctrl_o), .mask_o(mask_o), .scroll_x_o(scroll_x_o), .scroll_y_o(scroll_y_o),
        .vram_addr_o(vram_addr_o), .dot_o(dot_o), .line_o(line_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nt_phys(input logic mv, input logic [13:0] a);
        int o, t;
        o = int'(a & 14'h2FFF) - 'h2000;
        t = o / 1024;
        if (!mv) begin
            if (t == 1 || t == 2) o -= 'h400;
            else if (t == 3)      o -= 'h800;
        end else if (t >= 2) begin
            o -= 'h800;
        end
        return o;
    endfunction

    task automatic wr(input logic [2:0] p, input logic [7:0] d);
        @(negedge clk);
        acc_stb = 1'b1; acc_we = 1'b1; acc_port = p; acc_wdata = d;
        @(negedge clk);
        acc_stb = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] p, output logic [7:0] d);
        @(negedge clk);
        acc_stb = 1'b1; acc_we = 1'b0; acc_port = p;
        @(negedge clk);
        acc_stb = 1'b0;
        d = acc_rdata;
    endtask

    task automatic set_addr(input logic [13:0] a);
        logic [7:0] x;
        rd(3'd2, x);
        wr(3'd6, {2'b00, a[13:8]});
        wr(3'd6, a[7:0]);
    endtask

    task automatic nt_write(input logic [13:0] a, input logic [7:0] d);
        set_addr(a);
        wr(3'd7, d);
        ntm[nt_phys(mirror_vert, a)] = d;
    endtask

    task automatic nt_read(input logic [13:0] a, output logic [7:0] d);
        logic [7:0] x;
        set_addr(a);
        rd(3'd7, x);
        rd(3'd7, d);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: vblank_set = 1'b1;
            1: sprite0_set = 1'b1;
            2: overflow_set = 1'b1;
            default: flags_clr = 1'b1;
        endcase
        @(negedge clk);
        vblank_set = 1'b0; sprite0_set = 1'b0; overflow_set = 1'b0; flags_clr = 1'b0;
    endtask

    task automatic wait_dot(input int v);
        while (int'(dot_o) != v) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 190000);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        int bad;
        logic [13:0] a;

        repeat (3) @(negedge clk);
        // R1 reset values while reset still held
        chk("R1 dot", dot_o, 0);
        chk("R1 line", line_o, 0);
        chk("R1 vaddr", vram_addr_o, 0);
        chk("R1 ctrl", ctrl_o, 0);
        chk("R1 mask/scroll", {mask_o, scroll_x_o, scroll_y_o}, 0);
        chk("R1 rdata", acc_rdata, 0);
        rst = 1'b0;
        rd(3'd2, v);
        chk("R1 status", v, 8'h00);
        rd(3'd7, v);
        chk("R1 read buffer", v, 8'h00);

        // R2 control and mask sweeps
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            wr(3'd0, 8'(i));
            if (ctrl_o !== 8'(i)) bad++;
            wr(3'd1, 8'(255 - i));
            if (mask_o !== 6'(255 - i)) bad++;
        end
        chk("R2 ctrl/mask sweep mismatches", bad, 0);
        wr(3'd0, 8'h00);

        // R12 write-only ports read as zero
        wr(3'd1, 8'h2A); wr(3'd3, 8'h33); wr(3'd5, 8'h44); wr(3'd5, 8'h55);
        wr(3'd0, 8'h83);
        foreach (v2[i]) ;
        rd(3'd0, v); chk("R12 port0 read", v, 0);
        rd(3'd1, v); chk("R12 port1 read", v, 0);
        rd(3'd3, v); chk("R12 port3 read", v, 0);
        rd(3'd5, v); chk("R12 port5 read", v, 0);
        rd(3'd6, v); chk("R12 port6 read", v, 0);
        wr(3'd0, 8'h00);

        // R3 status flags
        pulse(0); pulse(1); pulse(2);
        rd(3'd2, v); chk("R3 status all set", v, 8'hE0);
        rd(3'd2, v); chk("R3 vblank cleared by read", v, 8'h60);
        pulse(3);
        rd(3'd2, v); chk("R3 flags_clr", v, 8'h00);
        pulse(0);
        wr(3'd2, 8'h00);
        rd(3'd2, v); chk("R12 status write ignored", v, 8'h80);

        // R3/R5 toggle reset by status read, scroll pair
        wr(3'd5, 8'h11);
        chk("R5 first scroll write", scroll_x_o, 8'h11);
        wr(3'd5, 8'h22);
        chk("R5 second scroll write", scroll_y_o, 8'h22);
        wr(3'd5, 8'h66);
        rd(3'd2, v);
        wr(3'd5, 8'h77);
        chk("R3 toggle reset by status read", {scroll_x_o, scroll_y_o}, 16'h7722);

        // R4 address port
        rd(3'd2, v);
        wr(3'd6, 8'h7F);
        chk("R4 high write masked", vram_addr_o, 14'h3F00);
        wr(3'd6, 8'hC5);
        chk("R4 low write", vram_addr_o, 14'h3FC5);
        // R5 shared toggle across scroll and address ports
        set_addr(14'h2100);
        wr(3'd5, 8'h33);
        wr(3'd6, 8'h34);
        chk("R5 shared toggle addr", vram_addr_o, 14'h2134);
        chk("R5 shared toggle scroll", {scroll_x_o, scroll_y_o}, 16'h3322);
        set_addr(14'h3FFF);
        chk("R4 14-bit address", vram_addr_o, 14'h3FFF);
        wr(3'd7, 8'hE1);
        ntm[nt_phys(mirror_vert, 14'h3FFF)] = 8'hE1;
        chk("R6 address wraps at 14 bits", vram_addr_o, 14'h0000);

        // R8 mirroring sweep: all tables, both modes, both windows
        for (int m = 0; m < 2; m++) begin
            mirror_vert = m[0];
            for (int t = 0; t < 4; t++) begin
                for (int k = 0; k < 3; k++) begin
                    a = ((t % 2 == 0) ? 14'h2000 : 14'h3000) + 14'(t * 'h400)
                        + ((k == 0) ? 14'h000 : (k == 1) ? 14'h155 : 14'h3FF);
                    nt_write(a, {m[0], t[1:0], 3'(k), 2'(t + k)});
                end
            end
            bad = 0;
            for (int t = 0; t < 4; t++) begin
                for (int k = 0; k < 3; k++) begin
                    a = 14'h2000 + 14'(t * 'h400)
                        + ((k == 0) ? 14'h000 : (k == 1) ? 14'h155 : 14'h3FF);
                    nt_read(a, v);
                    if (v !== ntm[nt_phys(mirror_vert, a)]) begin
                        bad++;
                        $display("FAIL R8 mode=%0d addr=%0h actual=%0h expected=%0h",
                                 m, a, v, ntm[nt_phys(mirror_vert, a)]);
                    end
                end
            end
            chk("R8 mirror sweep mismatches", bad, 0);
        end

        // R7 pattern-space write dropped
        mirror_vert = 1'b0;
        nt_write(14'h2040, 8'h11);
        set_addr(14'h0040);
        wr(3'd7, 8'h99);
        chk("R7 address advance", vram_addr_o, 14'h0041);
        nt_read(14'h2040, v);
        chk("R7 pattern write dropped", v, 8'h11);

        // R6/R13 buffered reads with step 32
        wr(3'd0, 8'h04);
        set_addr(14'h0100);
        rd(3'd7, v);
        bad = 0;
        for (int k = 0; k < 12; k++) begin
            rd(3'd7, v);
            if (v !== pat(13'(14'h0100 + k * 32))) bad++;
        end
        chk("R6 step-32 buffered reads", bad, 0);
        chk("R6 address after step 32", vram_addr_o, 14'h0100 + 14'(13 * 32));

        // R13 crossing from pattern to nametable space, step 1
        wr(3'd0, 8'h00);
        nt_write(14'h2000, 8'h5C);
        set_addr(14'h1FFD);
        rd(3'd7, v);
        rd(3'd7, v); chk("R13 pattern 1FFD", v, pat(13'h1FFD));
        rd(3'd7, v); chk("R13 pattern 1FFE", v, pat(13'h1FFE));
        rd(3'd7, v); chk("R13 pattern 1FFF", v, pat(13'h1FFF));
        rd(3'd7, v); chk("R6 first nametable byte after crossing", v, 8'h5C);

        // R9 sprite memory sweep
        wait_dot(0);
        wr(3'd3, 8'h00);
        for (int i = 0; i < 64; i++) wr(3'd4, 8'(i * 5 + 7));
        for (int h = 0; h < 2; h++) begin
            wait_dot(0);
            bad = 0;
            for (int i = h * 32; i < h * 32 + 32; i++) begin
                wr(3'd3, 8'(i));
                rd(3'd4, v);
                rd(3'd4, v2);
                if (v !== 8'(i * 5 + 7) || v2 !== v) bad++;
            end
            chk("R9 sprite readback without increment", bad, 0);
        end
        wait_dot(0);
        wr(3'd3, 8'hFF);
        wr(3'd4, 8'h77);
        wr(3'd4, 8'h88);
        wr(3'd3, 8'h00);
        rd(3'd4, v); chk("R9 address wraps to 0", v, 8'h88);
        wr(3'd3, 8'hFF);
        rd(3'd4, v); chk("R9 byte at FF", v, 8'h77);

        // R11 sprite address forced in window
        wait_dot(0);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'hA5);
        wr(3'd3, 8'h09);
        wr(3'd4, 8'h3C);
        wr(3'd3, 8'h09);
        wait_dot(290);
        rd(3'd4, v); chk("R11 forced to zero in window", v, 8'hA5);
        wr(3'd3, 8'h09);
        rd(3'd4, v); chk("R11 address write overridden", v, 8'hA5);
        wait_dot(330);
        rd(3'd4, v); chk("R11 stays zero after window", v, 8'hA5);
        wr(3'd3, 8'h09);
        rd(3'd4, v); chk("R11 normal after window", v, 8'h3C);

        // R10 counters through a full frame wrap
        bad = 0;
        for (int i = 0; i < DOTS * LINES + 700; i++) begin
            @(negedge clk);
            if (int'(dot_o) != cyc % DOTS || int'(line_o) != (cyc / DOTS) % LINES) bad++;
        end
        chk("R10 dot/line counter mismatches", bad, 0);
        chk("R10 passed a frame wrap", (cyc >= DOTS * LINES) ? 1 : 0, 1);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule